// File: doc/BRIEF.md
# SPI Flash Controller with Memory-Mapped Window

This block sits between a simple 32-bit request/acknowledge bus and a single serial flash device. It owns three small configuration registers and a flash window. Software selects one of four transfer modes. In the manual (user) mode, every byte or word access to the window is shifted out on SPI or read back from it, and chip select is held by a software-controlled stop bit. A single transaction can therefore span any number of bus accesses. In the mapped modes, each window access becomes a complete SPI transaction that the block frames itself. Chip select falls, the configured opcode goes out, then 3 or 4 address bytes taken from the window offset, then 1 or 4 data bytes, and chip select rises again. The bus stays stalled until the frame has finished.

The sequencer is a single state machine with these states:
- `ST_IDLE` waits for a request.
- `ST_ACK` returns the single-cycle acknowledge.
- `ST_USER` shifts manual-mode bytes.
- `ST_OPCODE`, `ST_ADDR` and `ST_DATA` shift the three phases of a mapped frame.
- `ST_RELEASE` holds chip select high for one cycle before the acknowledge.

Its transitions are:
- IDLE→ACK for register accesses and ignored writes.
- IDLE→USER for manual window accesses, and IDLE→OPCODE for mapped window accesses.
- USER→ACK after the last data byte.
- OPCODE→ADDR after the opcode byte.
- ADDR→DATA after the last address byte.
- DATA→RELEASE after the last data byte.
- RELEASE→ACK, then ACK→IDLE.

The serial link runs in SPI mode 0 (clock idles low, data sampled on the rising edge). A parameter sets the length of each half period.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset the configuration register (offset 0x00) reads 0, the addressing register (offset 0x04) reads 0, and the control register (offset 0x10) reads 0x0003_0004. That value means read mode, opcode 0x03 and stop bit set. After reset `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: Register fields read back with all other bits zero. Write-enable is bit 16 of offset 0x00. 4-byte addressing is bit 0 of offset 0x04. In the control register at offset 0x10, the mode is bits 1:0 (0 read, 1 fast read, 2 write, 3 user), the stop bit is bit 2 and the opcode is bits 23:16. A register access is acknowledged in the cycle after the request is first seen.
- R3: A window write while write-enable is 0 produces no SPI frame and is acknowledged in the cycle after the request.
- R4: In user mode `spi_cs_n` equals the stop bit. A byte write shifts `bus_wdata[7:0]` out most significant bit first.
- R5: A user-mode word write sends `bus_wdata` bits 31:24 first and bits 7:0 last. Consecutive accesses while the stop bit is 0 stay in one chip-select frame.
- R6: A user-mode read shifts out 0x00. A byte read returns the received byte in bits 7:0 with the upper bits zero. A word read places the first received byte in bits 31:24.
- R7: In read or fast-read mode, a window read sends the opcode, then the window offset as 3 bytes most significant first, then 0x00 for each data byte. It returns the data like R6 and ends with `spi_cs_n` high.
- R8: With 4-byte addressing set, mapped accesses send the offset as 4 bytes, zero-extended.
- R9: In write mode with write-enable set, a window write sends the opcode, the address and then the data (word most significant byte first, or a single byte) in one frame.
- R10: A window write in read or fast-read mode produces no SPI frame and is acknowledged in the cycle after the request.
- R11: `spi_mosi` changes only while `spi_sck` is low.
- R12: `bus_ready` is a single-cycle pulse. For a mapped access it comes only after `spi_cs_n` has returned high, at least 16·`HALF_DIV` cycles per shifted byte after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Request, held until `bus_ready` |
| bus_win | input | 1 | 1 = flash window, 0 = registers |
| bus_we | input | 1 | 1 = write |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte |
| bus_addr | input | ADDR_W | Register offset or window offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Acknowledge pulse |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Register accesses, ignored writes and writes in a read mode are due exactly one cycle after the request edge. The bench counts the clock edges to the acknowledge and compares that count with 1. Serial accesses are due after every byte has shifted. For these the bench only checks a lower bound on the latency, and it checks the frame captured by a behavioural flash model once the acknowledge has been seen. The model answers byte k of each frame with 0xC0+k, so the expected read data follows from the frame position alone. In user mode, chip select is compared on every clock against the stop bit last written, sampled just after the falling clock edge.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_FREAD = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_USER  = 2'd3
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_USER,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_RELEASE
    } seq_state_e;

    localparam logic [7:0] OFS_CFG  = 8'h00;
    localparam logic [7:0] OFS_ADR  = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h10;

    localparam logic [7:0] RST_OPCODE = 8'h03;

endpackage

// File: rtl/spi_flash_regs.sv
module spi_flash_regs
    import spi_flash_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [7:0]  ofs,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        wr_enable,
    output logic        addr4,
    output xfer_mode_e  mode,
    output logic        cs_stop,
    output logic [7:0]  opcode
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_enable <= 1'b0;
            addr4     <= 1'b0;
            mode      <= MODE_READ;
            cs_stop   <= 1'b1;
            opcode    <= RST_OPCODE;
        end else if (wr) begin
            unique case (ofs)
                OFS_CFG:  wr_enable <= wdata[16];
                OFS_ADR:  addr4     <= wdata[0];
                OFS_CTRL: begin
                    mode    <= xfer_mode_e'(wdata[1:0]);
                    cs_stop <= wdata[2];
                    opcode  <= wdata[23:16];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_CFG:  rdata = {15'b0, wr_enable, 16'b0};
            OFS_ADR:  rdata = {31'b0, addr4};
            OFS_CTRL: rdata = {8'b0, opcode, 13'b0, cs_stop, mode};
            default:  rdata = 32'b0;
        endcase
    end

endmodule

// File: rtl/spi_flash_shifter.sv
module spi_flash_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sck,
    output logic       mosi
);

    localparam int CNT_W = $clog2(HALF_DIV) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       bit_q;
    logic [7:0]       tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            rx    <= 8'h00;
            sck   <= 1'b0;
            mosi  <= 1'b0;
            cnt_q <= '0;
            bit_q <= '0;
            tx_q  <= 8'h00;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    tx_q  <= tx;
                    mosi  <= tx[7];
                    cnt_q <= '0;
                    bit_q <= '0;
                    sck   <= 1'b0;
                end
            end else if (cnt_q == CNT_W'(HALF_DIV - 1)) begin
                cnt_q <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_q == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                        mosi  <= tx_q[6];
                    end
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              win,
    input  logic              we,
    input  logic              word,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_enable,
    input  logic              addr4,
    input  xfer_mode_e        mode,
    input  logic [7:0]        opcode,
    input  logic [31:0]       reg_rdata,
    output logic              reg_wr,
    output logic [31:0]       rdata,
    output logic              ready,
    output logic              map_act,
    output logic              idle,
    output logic              sh_start,
    output logic [7:0]        sh_tx,
    input  logic              sh_busy,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx
);

    seq_state_e        state_q, state_d;
    logic [1:0]        idx_q;
    logic              sent_q;
    logic              we_q, word_q;
    logic [ADDR_W-1:0] off_q;
    logic [31:0]       wd_q;
    logic [31:0]       addr32;
    logic [1:0]        alast, dlast, asel, dsel;
    logic              ignore_wr, byte_state, last_byte;

    assign addr32    = 32'(off_q);
    assign alast     = addr4 ? 2'd3 : 2'd2;
    assign dlast     = word_q ? 2'd3 : 2'd0;
    assign asel      = alast - idx_q;
    assign dsel      = word_q ? (2'd3 - idx_q) : 2'd0;
    assign ignore_wr = we && (!wr_enable || (mode != MODE_USER && mode != MODE_WRITE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) begin
                if (!win || ignore_wr)     state_d = ST_ACK;
                else if (mode == MODE_USER) state_d = ST_USER;
                else                        state_d = ST_OPCODE;
            end
            ST_USER:    if (sh_done && idx_q == dlast) state_d = ST_ACK;
            ST_OPCODE:  if (sh_done)                   state_d = ST_ADDR;
            ST_ADDR:    if (sh_done && idx_q == alast) state_d = ST_DATA;
            ST_DATA:    if (sh_done && idx_q == dlast) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_ACK;
            ST_ACK:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready      = (state_q == ST_ACK);
        idle       = (state_q == ST_IDLE);
        map_act    = 1'b0;
        byte_state = 1'b0;
        last_byte  = 1'b0;
        sh_tx      = 8'h00;
        reg_wr     = (state_q == ST_IDLE) && req && !win && we;
        unique case (state_q)
            ST_USER: begin
                byte_state = 1'b1;
                last_byte  = (idx_q == dlast);
                sh_tx      = we_q ? wd_q[8*dsel +: 8] : 8'h00;
            end
            ST_OPCODE: begin
                byte_state = 1'b1;
                map_act    = 1'b1;
                last_byte  = 1'b1;
                sh_tx      = opcode;
            end
            ST_ADDR: begin
                byte_state = 1'b1;
                map_act    = 1'b1;
                last_byte  = (idx_q == alast);
                sh_tx      = addr32[8*asel +: 8];
            end
            ST_DATA: begin
                byte_state = 1'b1;
                map_act    = 1'b1;
                last_byte  = (idx_q == dlast);
                sh_tx      = we_q ? wd_q[8*dsel +: 8] : 8'h00;
            end
            default: ;
        endcase
        sh_start = byte_state && !sent_q && !sh_busy;
    end

    // request capture, byte index and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            sent_q <= 1'b0;
            we_q   <= 1'b0;
            word_q <= 1'b0;
            off_q  <= '0;
            wd_q   <= '0;
            rdata  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (req) begin
                we_q   <= we;
                word_q <= word;
                off_q  <= addr;
                wd_q   <= wdata;
                idx_q  <= '0;
                sent_q <= 1'b0;
                rdata  <= (!win && !we) ? reg_rdata : 32'b0;
            end
        end else if (byte_state) begin
            if (sh_start) sent_q <= 1'b1;
            if (sh_done) begin
                sent_q <= 1'b0;
                idx_q  <= last_byte ? 2'd0 : idx_q + 2'd1;
                if ((state_q == ST_USER || state_q == ST_DATA) && !we_q)
                    rdata <= word_q ? {rdata[23:0], sh_rx} : {24'b0, sh_rx};
            end
        end
    end

endmodule

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_win,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic        reg_wr, wr_enable, addr4, cs_stop;
    logic        map_act, seq_idle;
    logic [7:0]  opcode;
    logic [31:0] reg_rdata;
    xfer_mode_e  cur_mode;
    logic        sh_start, sh_busy, sh_done;
    logic [7:0]  sh_tx, sh_rx;

    spi_flash_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .ofs(bus_addr[7:0]),
        .wdata(bus_wdata), .rdata(reg_rdata), .wr_enable(wr_enable),
        .addr4(addr4), .mode(cur_mode), .cs_stop(cs_stop), .opcode(opcode)
    );

    spi_flash_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .win(bus_win), .we(bus_we),
        .word(bus_word), .addr(bus_addr), .wdata(bus_wdata),
        .wr_enable(wr_enable), .addr4(addr4), .mode(cur_mode), .opcode(opcode),
        .reg_rdata(reg_rdata), .reg_wr(reg_wr), .rdata(bus_rdata),
        .ready(bus_ready), .map_act(map_act), .idle(seq_idle),
        .sh_start(sh_start), .sh_tx(sh_tx), .sh_busy(sh_busy),
        .sh_done(sh_done), .sh_rx(sh_rx)
    );

    spi_flash_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx),
        .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx(sh_rx),
        .sck(spi_sck), .mosi(spi_mosi)
    );

    assign spi_cs_n = (cur_mode == MODE_USER) ? cs_stop : !map_act;

endmodule

// File: rtl/spi_flash_ctl_chk.sv
module spi_flash_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_win,
    input logic bus_ready,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi,
    input logic mode_user,
    input logic seq_idle
);

    a_r2_reg_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_win && seq_idle |=> bus_ready);

    a_r12_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    a_r12_cs_released: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready && !mode_user |-> spi_cs_n);

    a_r7_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n && !mode_user |-> !spi_sck);

    a_r11_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck && $past(spi_sck) |-> $stable(spi_mosi));

endmodule

bind spi_flash_ctl spi_flash_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win),
    .bus_ready(bus_ready), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .mode_user(cur_mode == spi_flash_pkg::MODE_USER),
    .seq_idle(seq_idle)
);

// File: tb/test_spi_flash_ctl.sv
module test_spi_flash_ctl;

    localparam int ADDR_W   = 24;
    localparam int HALF_DIV = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0, bus_win = 1'b0, bus_we = 1'b0, bus_word = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ready, spi_sck, spi_cs_n, spi_mosi;
    logic              spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_flash_ctl #(.ADDR_W(ADDR_W), .HALF_DIV(HALF_DIV)) i_spi_flash_ctl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win),
        .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // behavioural flash: records frames, answers byte k with 0xC0+k
    int         bitcnt = 0;
    logic [7:0] cur = 8'h00;
    logic [7:0] cur_frame[$];
    logic [7:0] last_frame[$];
    int         frame_cnt = 0;

    function automatic logic [7:0] reply(int k);
        return 8'(8'hC0 + k);
    endfunction

    always @(negedge spi_cs_n) begin
        bitcnt = 0;
        cur_frame = {};
        spi_miso = reply(0)[7];
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        cur = {cur[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0) cur_frame.push_back(cur);
    end
    always @(negedge spi_sck) if (!spi_cs_n)
        spi_miso = reply(bitcnt / 8)[7 - bitcnt % 8];
    always @(posedge spi_cs_n) begin
        last_frame = cur_frame;
        frame_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cycle-by-cycle chip-select reference while in user mode
    logic cs_track = 1'b0;
    logic cs_exp   = 1'b1;
    always @(negedge clk) begin
        #1;
        if (cs_track) check("R4 cs follows stop bit", 32'(spi_cs_n), 32'(cs_exp));
    end

    task automatic bus(input logic win, input logic we, input logic word,
                       input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int lat);
        @(negedge clk);
        bus_req = 1'b1; bus_win = win; bus_we = we; bus_word = word;
        bus_addr = a; bus_wdata = wd;
        lat = 0;
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end while (!bus_ready);
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic check_frame(input string req, input logic [7:0] exp[$]);
        check({req, " frame length"}, 32'(last_frame.size()), 32'(exp.size()));
        for (int i = 0; i < exp.size() && i < last_frame.size(); i++)
            check({req, " frame byte"}, 32'(last_frame[i]), 32'(exp[i]));
    endtask

    task automatic wreg(input logic [7:0] ofs, input logic [31:0] v);
        logic [31:0] rd; int lat;
        bus(1'b0, 1'b1, 1'b1, ADDR_W'(ofs), v, rd, lat);
        check("R2 write ack latency", 32'(lat), 32'd1);
    endtask

    task automatic rreg(input string req, input logic [7:0] ofs, input logic [31:0] exp);
        logic [31:0] rd; int lat;
        bus(1'b0, 1'b0, 1'b1, ADDR_W'(ofs), 32'h0, rd, lat);
        check({req, " register value"}, rd, exp);
        check("R2 read ack latency", 32'(lat), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat, fc;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        check("R1 cs_n", 32'(spi_cs_n), 32'd1);
        check("R1 sck", 32'(spi_sck), 32'd0);
        rreg("R1", 8'h00, 32'h0);
        rreg("R1", 8'h04, 32'h0);
        rreg("R1", 8'h10, 32'h0003_0004);

        // R2 field masks
        wreg(8'h00, 32'hFFFF_FFFF); rreg("R2", 8'h00, 32'h0001_0000);
        wreg(8'h04, 32'hFFFF_FFFF); rreg("R2", 8'h04, 32'h0000_0001);
        wreg(8'h10, 32'hFFFF_FFFF); rreg("R2", 8'h10, 32'h00FF_0007);
        wreg(8'h00, 32'h0); wreg(8'h04, 32'h0);

        // R3 write-enable clear: write mode, no frame
        wreg(8'h10, 32'h0002_0002);
        fc = frame_cnt;
        bus(1'b1, 1'b1, 1'b1, 24'h000100, 32'h1234_5678, rd, lat);
        repeat (4) @(negedge clk);
        check("R3 no frame", 32'(frame_cnt), 32'(fc));
        check("R3 ack latency", 32'(lat), 32'd1);

        // R10 write in read mode with write-enable set
        wreg(8'h00, 32'h0001_0000);
        wreg(8'h10, 32'h0003_0000);
        fc = frame_cnt;
        bus(1'b1, 1'b1, 1'b1, 24'h000200, 32'hCAFE_F00D, rd, lat);
        repeat (4) @(negedge clk);
        check("R10 no frame", 32'(frame_cnt), 32'(fc));
        check("R10 ack latency", 32'(lat), 32'd1);

        // R4/R5/R6 user mode
        wreg(8'h10, 32'h0000_0007);
        cs_exp = 1'b1; cs_track = 1'b1;
        wreg(8'h10, 32'h0000_0003);
        cs_exp = 1'b0;
        fc = frame_cnt;
        bus(1'b1, 1'b1, 1'b0, 24'h0, 32'hFFFF_FF9F, rd, lat);
        bus(1'b1, 1'b0, 1'b1, 24'h0, 32'h0, rd, lat);
        check("R6 word read order", rd, 32'hC1C2_C3C4);
        bus(1'b1, 1'b0, 1'b0, 24'h0, 32'h0, rd, lat);
        check("R6 byte read", rd, 32'h0000_00C5);
        bus(1'b1, 1'b1, 1'b1, 24'h0, 32'h1122_3344, rd, lat);
        check("R5 still one frame", 32'(frame_cnt), 32'(fc));
        wreg(8'h10, 32'h0000_0007);
        cs_exp = 1'b1;
        @(negedge clk);
        cs_track = 1'b0;
        check("R5 frame count", 32'(frame_cnt), 32'(fc + 1));
        check_frame("R4 R5 R6", '{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                                  8'h11, 8'h22, 8'h33, 8'h44});

        // R7 mapped read, 3-byte address
        wreg(8'h10, 32'h0003_0000);
        bus(1'b1, 1'b0, 1'b1, 24'h123456, 32'h0, rd, lat);
        check("R7 word data", rd, 32'hC4C5_C6C7);
        check("R12 latency bound", 32'(lat >= 8 * 16 * HALF_DIV), 32'd1);
        check("R7 cs released", 32'(spi_cs_n), 32'd1);
        check_frame("R7", '{8'h03, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00});
        wreg(8'h10, 32'h000B_0001);
        bus(1'b1, 1'b0, 1'b0, 24'h000102, 32'h0, rd, lat);
        check("R7 byte data fast mode", rd, 32'h0000_00C4);
        check_frame("R7 fast", '{8'h0B, 8'h00, 8'h01, 8'h02, 8'h00});

        // R8 4-byte addressing
        wreg(8'h04, 32'h1);
        wreg(8'h10, 32'h0003_0000);
        bus(1'b1, 1'b0, 1'b1, 24'hABCDEF, 32'h0, rd, lat);
        check("R8 word data", rd, 32'hC5C6_C7C8);
        check_frame("R8", '{8'h03, 8'h00, 8'hAB, 8'hCD, 8'hEF, 8'h00, 8'h00, 8'h00, 8'h00});

        // R9 mapped write
        wreg(8'h10, 32'h0002_0002);
        bus(1'b1, 1'b1, 1'b1, 24'h000010, 32'hDEAD_BEEF, rd, lat);
        check("R12 write latency bound", 32'(lat >= 9 * 16 * HALF_DIV), 32'd1);
        check_frame("R9 word", '{8'h02, 8'h00, 8'h00, 8'h00, 8'h10,
                                 8'hDE, 8'hAD, 8'hBE, 8'hEF});
        wreg(8'h04, 32'h0);
        bus(1'b1, 1'b1, 1'b0, 24'h000020, 32'h0000_005A, rd, lat);
        check_frame("R9 byte", '{8'h02, 8'h00, 8'h00, 8'h20, 8'h5A});

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule